// File: doc/BRIEF.md
# I2C Register-File Slave

This block is the serial control port of a programmable clock generator. It is an I2C target with a fixed 7-bit address. It holds a byte-wide register array of 2^AW entries, which the rest of the clock generator reads and writes through a direct core port. Raw SCL and SDA come in from the pads. The block synchronizes both lines to the system clock and pulls SDA low through an open-drain enable.

A single address pointer serves every transfer and survives from one transaction to the next. After any byte is written or read, the pointer holds that byte's location plus one. The master therefore has several ways to reach the registers:

- It can write one byte or a run of bytes, starting at a location it names.
- It can read at the pointer without naming a location.
- It can name a location, issue a repeated START, and read from that location.
- It can keep reading consecutive locations for as long as it acknowledges.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The block acknowledges only a first byte whose upper seven bits equal DEV_ADDR (default 0x69), with bit 0 as the direction (0 write, 1 read). For any other address it sends no acknowledge, keeps SDA released until the next START or STOP, and leaves the pointer unchanged.
- R2: In a write, the byte after the address byte loads the pointer. Each further byte is stored at the pointer, and the pointer then increments.
- R3: Every byte the block receives in an addressed transaction is acknowledged by holding SDA low through the ninth SCL clock.
- R4: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. If either arrives in the middle of a byte, that byte is aborted and its partial bits are discarded.
- R5: A read without a preceding location returns the byte at n+1, where n is the location last written or read.
- R6: A repeated START right after the location byte ends the write. No data is stored, and the pointer keeps the location that was sent, so the following read returns that location.
- R7: In a read, the block sends the next byte each time the master acknowledges. After a master non-acknowledge it releases SDA and sends nothing more. SDA is released during every master acknowledge slot.
- R8: The pointer wraps from the top entry (0xFF by default) to 0x00, for both reads and writes.
- R9: At reset, and on any cycle with load_defaults high, every entry i takes the value i XOR DEF_XOR (default 0x5A).
- R10: core_rdata shows the entry at core_addr without a clock delay. core_we writes core_wdata at core_addr on the next edge. A write from I2C in the same cycle takes precedence.
- R11: sda_oe changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL from the pad |
| sda_i | input | 1 | Raw SDA from the pad (resolved bus level) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| load_defaults | input | 1 | Reload every entry with its default value |
| core_addr | input | AW | Core-side register index |
| core_we | input | 1 | Core-side write strobe |
| core_wdata | input | 8 | Core-side write data |
| core_rdata | output | 8 | Entry at core_addr |

## Verification
The bench builds the block with its default parameters: address 0x69, an 8-bit index giving 256 entries, and default mask 0x5A. With 256 entries, a three-byte write or read that starts at 0xFE crosses the wrap from 0xFF to 0x00. With the mask, every entry resets to a value distinct from its neighbours, so a read that lands one location off shows up at once. SCL runs at one fortieth of the system clock, which leaves room for the synchronizer delay. The bench models the open-drain bus as a wired AND of the master's line and the block's enable.

// File: rtl/i2c_regfile_slave.sv
`timescale 1ns/1ps
module i2c_regfile_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         AW       = 8,
  parameter logic [7:0] DEF_XOR  = 8'h5A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          load_defaults,
  input  logic [AW-1:0] core_addr,
  input  logic          core_we,
  input  logic [7:0]    core_wdata,
  output logic [7:0]    core_rdata
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_REG, ST_WR, ST_RD} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic       scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end

  assign scl_s = scl_sy[1];
  assign sda_s = sda_sy[1];

  logic scl_rise, scl_fall, start_c, stop_c, bus_ev;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  assign bus_ev   = start_c | stop_c;

  st_t           state;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic [AW-1:0] ptr;
  logic          rw, mack;
  logic [7:0]    mem [DEPTH];
  logic [7:0]    rd_byte;
  logic          rx_state, byte_done, wr_en, dev_hit;

  assign rd_byte   = mem[ptr];
  assign rx_state  = (state == ST_DEV) || (state == ST_REG) || (state == ST_WR);
  assign byte_done = ~bus_ev & scl_fall & (bitcnt == 4'd8) & rx_state;
  assign wr_en     = byte_done & (state == ST_WR);
  assign dev_hit   = (shreg[7:1] == DEV_ADDR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= 4'd0;
      shreg  <= 8'd0;
      ptr    <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_c) begin
      state  <= ST_DEV;
      bitcnt <= 4'd0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      state  <= ST_IDLE;
      bitcnt <= 4'd0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_REG, ST_WR: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            bitcnt <= 4'd9;
            if (state == ST_DEV && !dev_hit) begin
              state  <= ST_IDLE;
              bitcnt <= 4'd0;
            end else begin
              sda_oe <= 1'b1;
            end
            if (state == ST_DEV) rw  <= shreg[0];
            if (state == ST_REG) ptr <= shreg[AW-1:0];
            if (state == ST_WR)  ptr <= ptr + AW'(1);
          end else if (scl_fall && bitcnt == 4'd9) begin
            bitcnt <= 4'd0;
            sda_oe <= 1'b0;
            if (state == ST_DEV && rw) begin
              state  <= ST_RD;
              shreg  <= rd_byte;
              sda_oe <= ~rd_byte[7];
            end else if (state == ST_DEV) begin
              state <= ST_REG;
            end else begin
              state <= ST_WR;
            end
          end
        end
        ST_RD: begin
          if (scl_fall && bitcnt < 4'd7) begin
            shreg  <= {shreg[6:0], 1'b0};
            sda_oe <= ~shreg[6];
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd7) begin
            sda_oe <= 1'b0;
            ptr    <= ptr + AW'(1);
            bitcnt <= 4'd8;
          end else if (scl_rise && bitcnt == 4'd8) begin
            mack   <= ~sda_s;
            bitcnt <= 4'd9;
          end else if (scl_fall && bitcnt == 4'd9) begin
            bitcnt <= 4'd0;
            if (mack) begin
              shreg  <= rd_byte;
              sda_oe <= ~rd_byte[7];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end

  function automatic logic [7:0] def_val(int i);
    return 8'(i) ^ DEF_XOR;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= def_val(i);
    end else if (load_defaults) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= def_val(i);
    end else if (wr_en) begin
      mem[ptr] <= shreg;
    end else if (core_we) begin
      mem[core_addr] <= core_wdata;
    end

  assign core_rdata = mem[core_addr];

  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  p_ack_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_state && bitcnt == 4'd9) |-> sda_oe);

  p_mack_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD && bitcnt >= 4'd8) |-> !sda_oe);

  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr == AW'($past(ptr) + AW'(1))));

  p_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ev |=> (bitcnt == 4'd0));
endmodule

// File: tb/tb_i2c_regfile_slave.sv
`timescale 1ns/1ps
module tb_i2c_regfile_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_oe, sda_bus;
  logic       load_defaults = 1'b0, core_we = 1'b0;
  logic [7:0] core_addr = 8'd0, core_wdata = 8'd0, core_rdata;
  int         total = 0, bad = 0, oe_bad = 0;
  logic       oe_prev = 1'b0;
  bit         done = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_regfile_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .load_defaults(load_defaults), .core_addr(core_addr), .core_we(core_we),
    .core_wdata(core_wdata), .core_rdata(core_rdata));

  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_m) oe_bad++;
    oe_prev = sda_oe;
  end

  task automatic w(int n); repeat (n) @(negedge clk); endtask

  task automatic check(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1; w(Q); scl_m = 1; w(Q); sda_m = 0; w(Q); scl_m = 0; w(Q);
  endtask

  task automatic bus_stop;
    sda_m = 0; w(Q); scl_m = 1; w(Q); sda_m = 1; w(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; w(Q); scl_m = 1; w(2*Q); scl_m = 0; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1; w(Q); scl_m = 1; w(Q); ack = ~sda_bus; w(Q); scl_m = 0; w(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      w(Q); scl_m = 1; w(Q); b = {b[6:0], sda_bus}; w(Q); scl_m = 0;
    end
    w(Q); sda_m = ~mack; w(Q); scl_m = 1; w(2*Q); scl_m = 0; w(Q); sda_m = 1;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    core_addr = a; w(1); d = core_rdata;
  endtask

  task automatic addr_phase(input logic [7:0] ra);
    logic ack;
    bus_start;
    send_byte(8'hD2, ack); check("R1 write address ack", ack, 1);
    send_byte(ra, ack);    check("R3 location byte ack", ack, 1);
  endtask

  task automatic read_open;
    logic ack;
    bus_start;
    send_byte(8'hD3, ack); check("R1 read address ack", ack, 1);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R9 sda released after reset", sda_oe, 0);
    peek(8'h00, d); check("R9 default 0x00", d, 8'h5A);
    peek(8'h10, d); check("R10 core read 0x10", d, 8'h4A);
  endtask

  task automatic t_single_write;
    logic ack; logic [7:0] d;
    addr_phase(8'h20);
    send_byte(8'hC3, ack); check("R3 data ack", ack, 1);
    bus_stop;
    peek(8'h20, d); check("R2 single write stored", d, 8'hC3);
  endtask

  task automatic t_wrap_write;
    logic ack; logic [7:0] d;
    addr_phase(8'hFE);
    send_byte(8'h11, ack); check("R3 burst ack 1", ack, 1);
    send_byte(8'h22, ack); check("R3 burst ack 2", ack, 1);
    send_byte(8'h33, ack); check("R3 burst ack 3", ack, 1);
    bus_stop;
    peek(8'hFE, d); check("R2 burst 0xFE", d, 8'h11);
    peek(8'hFF, d); check("R2 burst 0xFF", d, 8'h22);
    peek(8'h00, d); check("R8 write wraps to 0x00", d, 8'h33);
  endtask

  task automatic t_current_read;
    logic [7:0] d;
    read_open; recv_byte(0, d); bus_stop;
    check("R5 current read after write at 0x00", d, 8'h5B);
    read_open; recv_byte(0, d); bus_stop;
    check("R5 current read after read at 0x01", d, 8'h58);
  endtask

  task automatic t_random_read;
    logic [7:0] d;
    addr_phase(8'h20);
    read_open; recv_byte(0, d); bus_stop;
    check("R6 random read via repeated start", d, 8'hC3);
    peek(8'h21, d); check("R6 nothing stored next location", d, 8'h7B);
    peek(8'h20, d); check("R6 location kept its data", d, 8'hC3);
  endtask

  task automatic t_seq_read;
    logic [7:0] d;
    addr_phase(8'hFE);
    read_open;
    recv_byte(1, d); check("R7 sequential byte 0xFE", d, 8'h11);
    recv_byte(1, d); check("R8 sequential byte 0xFF", d, 8'h22);
    recv_byte(0, d); check("R8 read wraps to 0x00", d, 8'h33);
    check("R7 released after nack", sda_oe, 0);
    bus_stop;
    read_open; recv_byte(0, d); bus_stop;
    check("R7 pointer follows last read", d, 8'h5B);
  endtask

  task automatic t_wrong_addr;
    logic ack; logic [7:0] d;
    bus_start;
    send_byte(8'hA0, ack); check("R1 foreign address not acked", ack, 0);
    send_byte(8'h40, ack); check("R1 stays silent after miss", ack, 0);
    bus_stop;
    read_open; recv_byte(0, d); bus_stop;
    check("R1 pointer untouched by foreign traffic", d, 8'h58);
  endtask

  task automatic t_abort;
    logic ack; logic [7:0] d;
    addr_phase(8'h30);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop;
    peek(8'h30, d); check("R4 partial byte discarded", d, 8'h6A);
    read_open; recv_byte(0, d); bus_stop;
    check("R4 pointer survives abort", d, 8'h6A);
  endtask

  task automatic t_core_write;
    logic [7:0] d;
    core_addr = 8'h40; core_wdata = 8'h99; core_we = 1; w(1); core_we = 0;
    addr_phase(8'h40);
    read_open; recv_byte(0, d); bus_stop;
    check("R10 core write seen over I2C", d, 8'h99);
  endtask

  task automatic t_load_defaults;
    logic [7:0] d;
    load_defaults = 1; w(1); load_defaults = 0;
    peek(8'h20, d); check("R9 reload 0x20", d, 8'h7A);
    peek(8'hFE, d); check("R9 reload 0xFE", d, 8'hA4);
    peek(8'h40, d); check("R9 reload 0x40", d, 8'h1A);
  endtask

  initial begin
    w(5); rst_n = 1; w(5);
    t_reset;
    t_single_write;
    t_wrap_write;
    t_current_read;
    t_random_read;
    t_seq_read;
    t_wrong_addr;
    t_abort;
    t_core_write;
    t_load_defaults;
    check("R11 sda_oe moved only while SCL low", oe_bad, 0);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule